// File: doc/BRIEF.md
# Add-On Side FIFO Port

This block is the local-logic side of a pair of 32-bit data FIFOs. The inbound FIFO is filled by the host side and drained by the local logic. The outbound FIFO is filled by the local logic and drained by the host side. The host side appears here only as a push port on the inbound FIFO and a show-ahead pop port on the outbound FIFO.

The local logic reaches the FIFOs in one of two ways. It can use a decoded register access: a select, an address, byte enables and read or write strobes. It can also use a pair of dedicated FIFO strobes that need no address. In synchronous timing the strobes act as enables, and every rising clock edge during an active access moves the FIFO by one entry. In asynchronous timing the dedicated strobes are resampled into the clock domain, and the release of a strobe moves the FIFO by one entry. The read bus is modelled as data plus an output enable.

An empty inbound FIFO keeps presenting the last word it gave out. A full outbound FIFO ignores writes.

Top module: `aobus_fifo_port`

## Requirements
- R1: Reading the inbound FIFO while it is empty changes nothing, and the bus shows the last word that was read out again (zero after reset).
- R2: A write from either path while the outbound FIFO is full leaves its contents and order untouched.
- R3: A register read is active when `ab_sel`, `ab_rd` are high and `ab_addr` equals `PORT_ADDR` (default 5'h04). While it is active, `ab_rdata_oe` is high in the same cycle and the inbound head is on `ab_rdata`. Each rising edge during the access pops exactly one entry.
- R4: A register strobe with an address other than `PORT_ADDR` drives nothing and pops nothing.
- R5: Dropping the read strobe lowers `ab_rdata_oe` at once. The next access shows the same pending word, because no edge advanced the FIFO in between.
- R6: On the register path, byte enable bit i gates data bits 8i+7..8i. A disabled lane reads as zero and is stored as zero.
- R7: The dedicated strobes `fifo_rd`/`fifo_wr` ignore `ab_addr`, `ab_be` and `ab_sel`, and move full-width words.
- R8: When `cfg_half` is high, every access on either path carries only bits 15..0, and bits 31..16 read and store as zero.
- R9: If a dedicated strobe and a register strobe are high in the same cycle, the output enable stays low, neither FIFO changes at that edge, and `port_err` sets and stays set until reset.
- R10: With `cfg_async` high, `fifo_rd` drives the head word for as long as it is held, and holding it pops nothing. Its release pops one entry at the fourth rising edge, counting the first edge that samples it low.
- R11: With `cfg_async` high, `fifo_wr` captures `ab_wdata` at each edge while it is held. Its release pushes the last captured word with the same latency as R10.
- R12: `in_empty`, `in_full`, `out_empty` and `out_full` show the FIFO state after the pop or push, and change only at rising clock edges.
- R13: `hp_push` is ignored when the inbound FIFO is full. `hp_rdata` shows the outbound head without a pop, and `hp_pop` advances it.
- R14: Synchronous reset empties both FIFOs, clears `port_err` and the held last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_async | input | 1 | Dedicated strobes advance on release instead of per edge |
| cfg_half | input | 1 | 16-bit access width |
| ab_sel | input | 1 | Register access select |
| ab_rd | input | 1 | Register read strobe |
| ab_wr | input | 1 | Register write strobe |
| ab_addr | input | 5 | Register address |
| ab_be | input | 4 | Byte enables, active high |
| fifo_rd | input | 1 | Dedicated FIFO read strobe |
| fifo_wr | input | 1 | Dedicated FIFO write strobe |
| ab_wdata | input | 32 | Write data from local logic |
| ab_rdata | output | 32 | Read data to local logic |
| ab_rdata_oe | output | 1 | Read bus drive enable |
| in_empty | output | 1 | Inbound FIFO empty |
| out_full | output | 1 | Outbound FIFO full |
| port_err | output | 1 | Sticky strobe-clash flag |
| hp_push | input | 1 | Host-side push into inbound FIFO |
| hp_wdata | input | 32 | Host-side push data |
| in_full | output | 1 | Inbound FIFO full |
| hp_pop | input | 1 | Host-side pop from outbound FIFO |
| hp_rdata | output | 32 | Outbound FIFO head |
| out_empty | output | 1 | Outbound FIFO empty |

## Verification
The bench drains the inbound FIFO past empty. A design that let the pointer wrap there would hand back an old stale entry instead of repeating the last word. It pauses and resumes a burst to catch a design that advances on strobe release in synchronous mode and so skips a word. It overfills the outbound FIFO from both paths, which exposes any design that overwrites the oldest entry. It also holds an asynchronous strobe over several edges, where a design that used the level instead of the release would pop more than once, and it raises a clash to show that a design ignoring the rule would push, pop or drive.

// File: rtl/aob_pkg.sv
package aob_pkg;
    localparam int BUS_W  = 32;
    localparam int BE_W   = BUS_W / 8;
    localparam int HALF_W = BUS_W / 2;
    localparam int ADDR_W = 5;

    typedef logic [BUS_W-1:0] word_t;

    typedef struct packed {
        logic drive;    // read bus enabled this cycle
        logic rd_step;  // pop inbound at next edge
        logic rd_be;    // read lanes gated by byte enables
        logic wr_step;  // push outbound at next edge
        logic wr_be;    // write lanes gated by byte enables
        logic clash;    // dedicated and register strobes together
    } access_t;

    function automatic word_t lane_mask(input logic [BE_W-1:0] be,
                                        input logic use_be,
                                        input logic half);
        word_t m;
        for (int i = 0; i < BE_W; i++)
            m[8*i +: 8] = (use_be && !be[i]) ? 8'h00 : 8'hFF;
        if (half)
            m[BUS_W-1:HALF_W] = '0;
        return m;
    endfunction
endpackage

// File: rtl/aob_fifo.sv
module aob_fifo
    import aob_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  word_t push_data,
    input  logic  pop,
    output word_t head,
    output logic  empty,
    output logic  full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    word_t             mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;
    word_t             last_q;
    logic              do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? last_q : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp     <= '0;
            rp     <= '0;
            cnt    <= '0;
            last_q <= '0;
        end else begin
            if (do_push)
                wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop) begin
                rp     <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
                last_q <= mem[rp];
            end
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/aob_strobe_edge.sv
module aob_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic strobe,
    output logic release_pulse
);
    logic s1, s2, s3, pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= 1'b0;
            s2      <= 1'b0;
            s3      <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            s1      <= strobe;
            s2      <= s1;
            s3      <= s2;
            pulse_q <= en && s3 && !s2;
        end
    end

    assign release_pulse = pulse_q;
endmodule

// File: rtl/aob_access_decode.sv
module aob_access_decode
    import aob_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR = 5'h04
) (
    input  logic              cfg_async,
    input  logic              ab_sel,
    input  logic              ab_rd,
    input  logic              ab_wr,
    input  logic [ADDR_W-1:0] ab_addr,
    input  logic              fifo_rd,
    input  logic              fifo_wr,
    output access_t           acc
);
    logic hit, reg_rd, reg_wr, clash;

    assign hit    = ab_sel && (ab_addr == PORT_ADDR);
    assign reg_rd = hit && ab_rd;
    assign reg_wr = hit && ab_wr;
    assign clash  = (fifo_rd || fifo_wr) && (ab_rd || ab_wr);

    always_comb begin
        acc.clash   = clash;
        acc.drive   = !clash && (reg_rd || fifo_rd);
        acc.rd_step = !clash && (reg_rd || (fifo_rd && !cfg_async));
        acc.rd_be   = reg_rd;
        acc.wr_step = !clash && (reg_wr || (fifo_wr && !cfg_async));
        acc.wr_be   = reg_wr;
    end
endmodule

// File: rtl/aobus_fifo_port.sv
module aobus_fifo_port
    import aob_pkg::*;
#(
    parameter int                DEPTH     = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 5'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_async,
    input  logic              cfg_half,
    input  logic              ab_sel,
    input  logic              ab_rd,
    input  logic              ab_wr,
    input  logic [ADDR_W-1:0] ab_addr,
    input  logic [BE_W-1:0]   ab_be,
    input  logic              fifo_rd,
    input  logic              fifo_wr,
    input  logic [BUS_W-1:0]  ab_wdata,
    output logic [BUS_W-1:0]  ab_rdata,
    output logic              ab_rdata_oe,
    output logic              in_empty,
    output logic              out_full,
    output logic              port_err,
    input  logic              hp_push,
    input  logic [BUS_W-1:0]  hp_wdata,
    output logic              in_full,
    input  logic              hp_pop,
    output logic [BUS_W-1:0]  hp_rdata,
    output logic              out_empty
);
    access_t acc;
    logic    arel_rd, arel_wr;
    word_t   in_head, out_push_data, hold_q;
    logic    err_q;

    aob_access_decode #(.PORT_ADDR(PORT_ADDR)) u_dec (
        .cfg_async (cfg_async),
        .ab_sel    (ab_sel),
        .ab_rd     (ab_rd),
        .ab_wr     (ab_wr),
        .ab_addr   (ab_addr),
        .fifo_rd   (fifo_rd),
        .fifo_wr   (fifo_wr),
        .acc       (acc)
    );

    aob_strobe_edge u_rel_rd (
        .clk(clk), .rst(rst), .en(cfg_async), .strobe(fifo_rd), .release_pulse(arel_rd)
    );

    aob_strobe_edge u_rel_wr (
        .clk(clk), .rst(rst), .en(cfg_async), .strobe(fifo_wr), .release_pulse(arel_wr)
    );

    // Asynchronous write data is taken while the strobe is held.
    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (cfg_async && fifo_wr)
            hold_q <= ab_wdata & lane_mask('0, 1'b0, cfg_half);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q || acc.clash;
    end

    assign out_push_data = arel_wr ? hold_q
                                   : (ab_wdata & lane_mask(ab_be, acc.wr_be, cfg_half));

    aob_fifo #(.DEPTH(DEPTH)) u_in (
        .clk       (clk),
        .rst       (rst),
        .push      (hp_push),
        .push_data (hp_wdata),
        .pop       (acc.rd_step || arel_rd),
        .head      (in_head),
        .empty     (in_empty),
        .full      (in_full)
    );

    aob_fifo #(.DEPTH(DEPTH)) u_out (
        .clk       (clk),
        .rst       (rst),
        .push      (acc.wr_step || arel_wr),
        .push_data (out_push_data),
        .pop       (hp_pop),
        .head      (hp_rdata),
        .empty     (out_empty),
        .full      (out_full)
    );

    assign ab_rdata_oe = acc.drive;
    assign ab_rdata    = acc.drive ? (in_head & lane_mask(ab_be, acc.rd_be, cfg_half)) : '0;
    assign port_err    = err_q;
endmodule

// File: rtl/aob_port_chk.sv
module aob_port_chk
    import aob_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_half,
    input logic             ab_rd,
    input logic             ab_wr,
    input logic             fifo_rd,
    input logic             fifo_wr,
    input logic [BUS_W-1:0] ab_rdata,
    input logic             ab_rdata_oe,
    input logic             in_empty,
    input logic             in_full,
    input logic             out_empty,
    input logic             out_full,
    input logic             port_err,
    input logic             hp_push,
    input logic             hp_pop
);
    a_r1_empty_holds: assert property (@(posedge clk) disable iff (rst)
        in_empty && !hp_push |=> in_empty);

    a_r2_full_holds: assert property (@(posedge clk) disable iff (rst)
        out_full && !hp_pop |=> out_full);

    a_r5_idle_floats: assert property (@(posedge clk) disable iff (rst)
        !ab_rd && !fifo_rd |-> !ab_rdata_oe);

    a_r8_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_half |-> ab_rdata[BUS_W-1:HALF_W] == '0);

    a_r9_clash_no_drive: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd || fifo_wr) && (ab_rd || ab_wr) |-> !ab_rdata_oe);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        port_err |=> port_err);

    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(in_empty && in_full) && !(out_empty && out_full));

    a_r14_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> in_empty && out_empty && !port_err);
endmodule

bind aobus_fifo_port aob_port_chk u_chk (
    .clk(clk), .rst(rst), .cfg_half(cfg_half),
    .ab_rd(ab_rd), .ab_wr(ab_wr), .fifo_rd(fifo_rd), .fifo_wr(fifo_wr),
    .ab_rdata(ab_rdata), .ab_rdata_oe(ab_rdata_oe),
    .in_empty(in_empty), .in_full(in_full), .out_empty(out_empty), .out_full(out_full),
    .port_err(port_err), .hp_push(hp_push), .hp_pop(hp_pop)
);

// File: tb/sim_aobus_fifo_port.sv
module sim_aobus_fifo_port;
    import aob_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, cfg_async, cfg_half, ab_sel, ab_rd, ab_wr, fifo_rd, fifo_wr;
    logic hp_push, hp_pop;
    logic [4:0]  ab_addr;
    logic [3:0]  ab_be;
    logic [31:0] ab_wdata, hp_wdata, ab_rdata, hp_rdata;
    logic ab_rdata_oe, in_empty, out_full, port_err, in_full, out_empty;

    aobus_fifo_port u0 (.*);

    int n_vec = 0, n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic nxt(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        ab_sel = 0; ab_rd = 0; ab_wr = 0; fifo_rd = 0; fifo_wr = 0;
        hp_push = 0; hp_pop = 0; ab_addr = '0; ab_be = '0;
    endtask

    function automatic logic [31:0] vin(input int i);
        return 32'hA5C30000 + i * 32'h01020304;
    endfunction

    function automatic logic [31:0] vout(input int i);
        return 32'h3C7E1100 + i * 32'h11111111;
    endfunction

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1; cfg_async = 0; cfg_half = 0; ab_wdata = '0; hp_wdata = '0;
        nxt(3);
        rst = 0;
        nxt();
        // R14 reset state
        chk("R14 in_empty", in_empty, 1);
        chk("R14 out_empty", out_empty, 1);
        chk("R14 full flags", {in_full, out_full}, 0);
        chk("R14 err", port_err, 0);
        chk("R14 oe", ab_rdata_oe, 0);

        // R13 fill inbound, one extra push ignored
        for (int i = 0; i < 9; i++) begin
            hp_push = 1; hp_wdata = (i < 8) ? vin(i) : 32'hFFFF0000;
            nxt();
        end
        hp_push = 0;
        #2 chk("R13 R12 in_full", in_full, 1);

        // R3 synchronous register burst
        ab_sel = 1; ab_rd = 1; ab_addr = 5'h04; ab_be = 4'hF;
        for (int i = 0; i < 4; i++) begin
            #2 chk("R3 oe", ab_rdata_oe, 1);
            chk("R3 burst data", ab_rdata, vin(i));
            nxt();
        end
        // R5 pause and resume
        ab_rd = 0;
        #2 chk("R5 float", ab_rdata_oe, 0);
        nxt(2);
        ab_rd = 1;
        #2 chk("R5 resume word", ab_rdata, vin(4));
        // R4 wrong address
        ab_addr = 5'h05;
        #2 chk("R4 no drive", ab_rdata_oe, 0);
        nxt();
        ab_addr = 5'h04; ab_be = 4'b0101;
        // R6 read lanes
        #2 chk("R4 R6 no pop, lane mask", ab_rdata, vin(4) & 32'h00FF00FF);
        nxt();
        idle();

        // R7 direct read ignores addr/be/sel, R1 at empty
        fifo_rd = 1;
        for (int i = 5; i < 8; i++) begin
            #2 chk("R7 direct data", ab_rdata, vin(i));
            nxt();
        end
        #2 chk("R1 R12 empty", in_empty, 1);
        chk("R1 repeat last", ab_rdata, vin(7));
        nxt();
        #2 chk("R1 still empty", in_empty, 1);
        chk("R1 repeat again", ab_rdata, vin(7));
        fifo_rd = 0;

        hp_push = 1; hp_wdata = 32'h12345678;
        nxt();
        hp_push = 0;
        #2 chk("R12 not empty", in_empty, 0);
        fifo_rd = 1;
        #2 chk("R7 new word", ab_rdata, 32'h12345678);
        nxt();
        fifo_rd = 0;

        // R8 half width read
        cfg_half = 1;
        hp_push = 1; hp_wdata = 32'hDEADBEEF;
        nxt();
        hp_push = 0; fifo_rd = 1;
        #2 chk("R8 half read", ab_rdata, 32'h0000BEEF);
        nxt();
        fifo_rd = 0; cfg_half = 0;

        // R2 R6 R7 R8 outbound fill and overfill
        ab_sel = 1; ab_wr = 1; ab_addr = 5'h04;
        for (int i = 0; i < 7; i++) begin
            ab_be = (i == 6) ? 4'b0011 : 4'hF;
            ab_wdata = vout(i);
            nxt();
        end
        ab_sel = 0; ab_wr = 0; ab_be = 4'h0; ab_addr = 5'h1F;
        cfg_half = 1; fifo_wr = 1; ab_wdata = vout(7);
        nxt();
        #2 chk("R2 R12 out_full", out_full, 1);
        ab_wdata = 32'hFFFFFFFF;
        nxt();
        fifo_wr = 0; cfg_half = 0;
        #2 chk("R2 still full", out_full, 1);
        for (int i = 0; i < 8; i++) begin
            #2 chk("R2 R6 R8 R13 outbound order", hp_rdata,
                   (i < 6) ? vout(i) : (vout(i) & 32'h0000FFFF));
            hp_pop = 1;
            nxt();
            hp_pop = 0;
        end
        #2 chk("R13 out_empty", out_empty, 1);

        // R9 clash
        idle();
        hp_push = 1; hp_wdata = 32'h0BADF00D;
        nxt();
        hp_push = 0;
        fifo_rd = 1; ab_sel = 1; ab_wr = 1; ab_addr = 5'h04; ab_be = 4'hF; ab_wdata = 32'h77777777;
        #2 chk("R9 no drive", ab_rdata_oe, 0);
        nxt();
        idle();
        #2 chk("R9 err set", port_err, 1);
        chk("R9 no pop", in_empty, 0);
        chk("R9 no push", out_empty, 1);
        nxt(3);
        chk("R9 err sticky", port_err, 1);

        // R10 asynchronous read
        cfg_async = 1;
        hp_push = 1; hp_wdata = 32'h5A5A0001;
        nxt();
        hp_push = 0; fifo_rd = 1;
        #2 chk("R10 drive", ab_rdata_oe, 1);
        chk("R10 head", ab_rdata, 32'h0BADF00D);
        nxt(4);
        chk("R10 held no pop", ab_rdata, 32'h0BADF00D);
        fifo_rd = 0;
        #2 chk("R10 float", ab_rdata_oe, 0);
        nxt(5);
        fifo_rd = 1;
        #2 chk("R10 one pop", ab_rdata, 32'h5A5A0001);
        nxt(2);
        fifo_rd = 0;
        nxt(5);
        chk("R10 R12 drained", in_empty, 1);

        // R11 asynchronous write
        fifo_wr = 1; ab_wdata = 32'hC0FFEE11;
        nxt(3);
        fifo_wr = 0; ab_wdata = 32'h0;
        nxt(5);
        chk("R11 pushed", out_empty, 0);
        chk("R11 data", hp_rdata, 32'hC0FFEE11);
        cfg_async = 0;

        // R14 reset again
        rst = 1;
        nxt(2);
        rst = 0;
        nxt();
        chk("R14 out_empty", out_empty, 1);
        chk("R14 err clear", port_err, 0);
        chk("R14 in_empty", in_empty, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule